// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block steps a programmable device from power-on through to active operation. Once supply is reported good, it runs three phases in strict order. First it wipes the configuration memory, through a request/acknowledge handshake with an external clearing engine. Next it accepts configuration frames until the frame writer reports that the last one has landed. Finally it runs a short start-up ritual that brings the user logic to life.

The init line is an open-drain wire shared with the board. The sequencer pulls it Low while memory is being wiped and lets go once the wipe is acknowledged. Any other agent may keep holding it Low, and loading then waits until the synchronised line reads High.

After the last frame, one global set/reset pulse clears every user flip-flop. On the following clock edges the sequencer raises DONE, then lifts the output-disable hold, then lifts the write-inhibit hold, one edge apart. A program request or a loss of supply tears the device back down at any moment, including after start-up has finished.

Top module: `cfg_startup_seq`

## Requirements
- R1: While reset is asserted, the outputs are held as follows:
  - init_drive_low = 1;
  - done = 0;
  - gts_hold = 1;
  - gwe_hold = 1;
  - gsr = 0;
  - clr_req = 0;
  - load_active = 0.
- R2: With pwr_good high and prog_n high after reset, clr_req rises within a few cycles. init_drive_low stays 1 for as long as clr_req is 1.
- R3: On the clock edge that samples clr_done high during the clear phase, the block leaves the clear phase. From the next cycle, clr_req = 0 and init_drive_low = 0.
- R4: While the sensed init line stays Low after clearing, load_active stays 0. After the line is sensed High, load_active rises exactly SYNC_STAGES+1 cycles later (3 by default).
- R5: load_done sampled high while load_active = 1 produces gsr = 1 for exactly one cycle, in the next cycle.
- R6: done rises in the cycle after the gsr pulse.
- R7: gts_hold falls one cycle after done rises.
- R8: gwe_hold falls one cycle after gts_hold falls.
- R9: prog_n sampled Low with pwr_good high returns the block to the clear phase from any phase. In the next cycle, clr_req = 1, init_drive_low = 1, done = 0, gts_hold = 1 and gwe_hold = 1.
- R10: pwr_good sampled Low forces the power-wait phase. In the next cycle, clr_req = 0, init_drive_low = 1, done = 0, gts_hold = 1 and gwe_hold = 1.
- R11: load_done outside the load phase has no effect. gsr stays 0 and done keeps its value.
- R12: clr_done outside the clear phase has no effect. clr_req and init_drive_low keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Power-on reset conditions met |
| prog_n | input | 1 | Active-low program request, synchronous to clk |
| init_sense | input | 1 | Sensed level of the open-drain init line |
| clr_done | input | 1 | Memory clearing engine finished |
| load_done | input | 1 | Last configuration frame written (strobe) |
| init_drive_low | output | 1 | Pull init line Low (open-drain enable) |
| clr_req | output | 1 | Request to the memory clearing engine |
| load_active | output | 1 | Data-load phase in progress |
| gsr | output | 1 | One-cycle global set/reset pulse |
| done | output | 1 | Configuration complete |
| gts_hold | output | 1 | High keeps all user outputs disabled |
| gwe_hold | output | 1 | High blocks internal storage writes |

## Verification
The in-RTL properties check the per-cycle rules on every clock:
- the exit from the clear phase on clr_done;
- the wait while the synchronised init line is Low;
- the one-cycle width of gsr and its cause;
- the DONE, output-enable, write-enable spacing;
- the response to a program request or a supply drop.

Some properties cannot be written as a single clocked rule, and only the bench scenarios show them:
- the exact latency through the init-line synchroniser after an external agent lets go;
- that stray handshake strobes in the wrong phase leave the outputs unchanged;
- that aborts injected mid-clear, mid-wait and mid-load recover into a clean full sequence.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

  // Phase encoding of the configuration sequencer
  typedef enum logic [2:0] {
    PH_PWR_WAIT = 3'd0,  // waiting for power-good
    PH_CLEAR    = 3'd1,  // memory wipe in progress
    PH_LINE     = 3'd2,  // wipe acknowledged, waiting for init line High
    PH_LOAD     = 3'd3,  // frames being written
    PH_RESET    = 3'd4,  // global set/reset pulse
    PH_LIVE     = 3'd5   // start-up running or finished
  } phase_e;

  // Start-up ladder: done, then output enable, then write enable
  localparam int unsigned STARTUP_RUNGS = 3;

endpackage

// File: rtl/cfgseq_rst_sync.sv
module cfgseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/cfgseq_line_sync.sv
module cfgseq_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_hi
);

  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic stage_d;
      if (g == 0) begin : g_first
        always_comb stage_d = line_in;
      end else begin : g_rest
        always_comb stage_d = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= 1'b0;
        end else begin
          stage_q[g] <= stage_d;
        end
      end
    end
  endgenerate

  assign line_hi = stage_q[STAGES-1];

endmodule

// File: rtl/cfgseq_phase_fsm.sv
module cfgseq_phase_fsm
  import cfgseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_good,
  input  logic   prog_n,
  input  logic   line_hi,
  input  logic   clr_done,
  input  logic   load_done,
  output phase_e phase,
  output logic   init_drive_low,
  output logic   clr_req,
  output logic   load_active,
  output logic   gsr,
  output logic   start_go,
  output logic   teardown
);

  phase_e phase_q;
  phase_e phase_d;
  logic   phase_en;

  // Next-state process
  always_comb begin
    phase_d = phase_q;
    if (!pwr_good) begin
      phase_d = PH_PWR_WAIT;
    end else if (!prog_n) begin
      phase_d = PH_CLEAR;
    end else begin
      unique case (phase_q)
        PH_PWR_WAIT: phase_d = PH_CLEAR;
        PH_CLEAR:    if (clr_done)  phase_d = PH_LINE;
        PH_LINE:     if (line_hi)   phase_d = PH_LOAD;
        PH_LOAD:     if (load_done) phase_d = PH_RESET;
        PH_RESET:    phase_d = PH_LIVE;
        PH_LIVE:     phase_d = PH_LIVE;
        default:     phase_d = PH_PWR_WAIT;
      endcase
    end
  end

  assign phase_en = (phase_d != phase_q);

  // Register process with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PWR_WAIT;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  // Decoded outputs
  assign phase          = phase_q;
  assign init_drive_low = (phase_q == PH_PWR_WAIT) || (phase_q == PH_CLEAR);
  assign clr_req        = (phase_q == PH_CLEAR);
  assign load_active    = (phase_q == PH_LOAD);
  assign gsr            = (phase_q == PH_RESET);
  assign teardown       = !pwr_good || !prog_n;
  assign start_go       = (phase_q == PH_RESET) && !teardown;

  // R3: an acknowledged wipe leaves the clear phase and releases the line
  assert_clear_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CLEAR && clr_done && prog_n && pwr_good)
      |=> (!init_drive_low && !clr_req));

  // R4: no loading while the synchronised line is Low
  assert_line_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LINE && !line_hi && prog_n && pwr_good)
      |=> (phase_q == PH_LINE));

  // R5: gsr lasts one cycle
  assert_gsr_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gsr |=> !gsr);

  // R5: gsr only follows a load completion in the load phase
  assert_gsr_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gsr) |-> $past(load_active && load_done));

  // R9: a program request lands in the clear phase
  assert_prog_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_n && pwr_good) |=> (clr_req && init_drive_low));

  // R10: a supply drop lands in the power-wait phase
  assert_pwr_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!clr_req && init_drive_low));

endmodule

// File: rtl/cfgseq_startup.sv
module cfgseq_startup #(
  parameter int unsigned RUNGS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic teardown,
  output logic done,
  output logic gts_hold,
  output logic gwe_hold
);

  logic [RUNGS-1:0] rung_q;
  logic [RUNGS-1:0] rung_d;
  logic             rung_en;

  // Next-state process: each rung follows the one below it, all sticky
  always_comb begin
    rung_d = rung_q;
    if (teardown) begin
      rung_d = '0;
    end else begin
      rung_d[0] = rung_q[0] | start_go;
    end
  end

  genvar r;
  generate
    for (r = 1; r < RUNGS; r++) begin : g_rung
      logic rung_nxt;
      always_comb rung_nxt = teardown ? 1'b0 : rung_q[r-1];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rung_q[r] <= 1'b0;
        end else if (rung_en) begin
          rung_q[r] <= rung_nxt;
        end
      end
    end
  endgenerate

  assign rung_en = teardown || start_go || (rung_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rung_q[0] <= 1'b0;
    end else if (rung_en) begin
      rung_q[0] <= rung_d[0];
    end
  end

  assign done     = rung_q[0];
  assign gts_hold = !rung_q[1];
  assign gwe_hold = !rung_q[RUNGS-1];

  // R6: done follows the start request
  assert_done_after_gsr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_go && !teardown) |=> done);

  // R7: output enable released one cycle after done
  assert_gts_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !teardown) |=> (!gts_hold && !gwe_hold == 1'b0));

  // R8: write enable released one cycle after output enable
  assert_gwe_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gts_hold) && !teardown) |=> !gwe_hold);

  // R9 and R10: a teardown drops every rung at once
  assert_teardown_R9: assert property (@(posedge clk) disable iff (!rst_n)
    teardown |=> (!done && gts_hold && gwe_hold));

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfgseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic prog_n,
  input  logic init_sense,
  input  logic clr_done,
  input  logic load_done,
  output logic init_drive_low,
  output logic clr_req,
  output logic load_active,
  output logic gsr,
  output logic done,
  output logic gts_hold,
  output logic gwe_hold
);

  localparam int unsigned RUNGS = STARTUP_RUNGS;

  logic   core_rst_n;
  logic   line_hi;
  logic   start_go;
  logic   teardown;
  phase_e phase;

  cfgseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (core_rst_n)
  );

  cfgseq_line_sync #(.STAGES(SYNC_STAGES)) u_line (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .line_in (init_sense),
    .line_hi (line_hi)
  );

  cfgseq_phase_fsm u_fsm (
    .clk            (clk),
    .rst_n          (core_rst_n),
    .pwr_good       (pwr_good),
    .prog_n         (prog_n),
    .line_hi        (line_hi),
    .clr_done       (clr_done),
    .load_done      (load_done),
    .phase          (phase),
    .init_drive_low (init_drive_low),
    .clr_req        (clr_req),
    .load_active    (load_active),
    .gsr            (gsr),
    .start_go       (start_go),
    .teardown       (teardown)
  );

  cfgseq_startup #(.RUNGS(RUNGS)) u_start (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .start_go (start_go),
    .teardown (teardown),
    .done     (done),
    .gts_hold (gts_hold),
    .gwe_hold (gwe_hold)
  );

  // R1: outside the clear or power-wait phases the line is never pulled Low
  assert_drive_phase_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (phase == PH_LOAD || phase == PH_LIVE) |-> !init_drive_low);

  // R11: done is never set while loading
  assert_no_done_load_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
    load_active |-> !done);

endmodule

// File: tb/tb_cfg_startup_seq.sv
module tb_cfg_startup_seq;

  localparam int SYNC = 2;

  logic clk;
  logic rst_n;
  logic pwr_good;
  logic prog_n;
  logic init_sense;
  logic clr_done;
  logic load_done;
  logic init_drive_low;
  logic clr_req;
  logic load_active;
  logic gsr;
  logic done;
  logic gts_hold;
  logic gwe_hold;
  logic ext_hold;

  int n_cmp;
  int n_bad;

  // Open-drain wired line: Low if anybody pulls it
  assign init_sense = !(init_drive_low || ext_hold);

  cfg_startup_seq #(.SYNC_STAGES(SYNC)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pwr_good       (pwr_good),
    .prog_n         (prog_n),
    .init_sense     (init_sense),
    .clr_done       (clr_done),
    .load_done      (load_done),
    .init_drive_low (init_drive_low),
    .clr_req        (clr_req),
    .load_active    (load_active),
    .gsr            (gsr),
    .done           (done),
    .gts_hold       (gts_hold),
    .gwe_hold       (gwe_hold)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int which);
    case (which)
      0:       return clr_req;
      1:       return load_active;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_sig(input int which, input int maxc, input string req, output int took);
    took = 0;
    while (!pick(which) && took < maxc) begin
      tick();
      took++;
    end
    chk(req, int'(pick(which)), 1);
  endtask

  task automatic prog_abort();
    prog_n = 1'b0;
    tick();
    prog_n = 1'b1;
    chk("R9 clr_req", int'(clr_req), 1);
    chk("R9 init_drive_low", int'(init_drive_low), 1);
    chk("R9 done", int'(done), 0);
    chk("R9 gts_hold", int'(gts_hold), 1);
    chk("R9 gwe_hold", int'(gwe_hold), 1);
  endtask

  // Expected start-up ladder state, n cycles after gsr
  function automatic int ladder(input int n, input int rung);
    return (n > rung) ? 1 : 0;
  endfunction

  task automatic do_config(input int hold, input int abort_ph, output bit finished);
    int took;
    finished = 1'b0;
    wait_sig(0, 30, "R2 clr_req", took);
    chk("R2 init low in clear", int'(init_drive_low), 1);
    // R11: stray load_done in clear phase
    load_done = 1'b1;
    tick();
    load_done = 1'b0;
    chk("R11 no gsr outside load", int'(gsr), 0);
    chk("R11 still clearing", int'(clr_req), 1);
    if (abort_ph == 1) begin
      prog_abort();
      return;
    end
    ext_hold = (hold > 0);
    clr_done = 1'b1;
    tick();
    clr_done = 1'b0;
    chk("R3 line released", int'(init_drive_low), 0);
    chk("R3 clr_req dropped", int'(clr_req), 0);
    for (int i = 0; i < hold; i++) begin
      tick();
      chk("R4 held off", int'(load_active), 0);
    end
    if (abort_ph == 2) begin
      ext_hold = 1'b0;
      prog_abort();
      return;
    end
    ext_hold = 1'b0;
    if (hold > 0) begin
      wait_sig(1, SYNC + 4, "R4 load reached", took);
      chk("R4 sync latency", took, SYNC + 1);
    end else begin
      wait_sig(1, SYNC + 4, "R4 load reached", took);
    end
    if (abort_ph == 3) begin
      prog_abort();
      return;
    end
    load_done = 1'b1;
    tick();
    load_done = 1'b0;
    chk("R5 gsr pulse", int'(gsr), 1);
    chk("R6 done before start", int'(done), 0);
    for (int n = 1; n <= 3; n++) begin
      tick();
      chk("R5 gsr one cycle", int'(gsr), 0);
      chk("R6 done", int'(done), ladder(n, 0));
      chk("R7 gts_hold", int'(gts_hold), 1 - ladder(n, 1));
      chk("R8 gwe_hold", int'(gwe_hold), 1 - ladder(n, 2));
    end
    finished = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit fin;
    int hold;
    int ab;
    int act;
    n_cmp = 0;
    n_bad = 0;
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    pwr_good  = 1'b0;
    prog_n    = 1'b1;
    clr_done  = 1'b0;
    load_done = 1'b0;
    ext_hold  = 1'b0;
    repeat (3) tick();
    chk("R1 init_drive_low", int'(init_drive_low), 1);
    chk("R1 done", int'(done), 0);
    chk("R1 gts_hold", int'(gts_hold), 1);
    chk("R1 gwe_hold", int'(gwe_hold), 1);
    chk("R1 gsr", int'(gsr), 0);
    chk("R1 clr_req", int'(clr_req), 0);
    chk("R1 load_active", int'(load_active), 0);
    rst_n = 1'b1;
    repeat (5) tick();
    chk("R10 no clear without power", int'(clr_req), 0);
    chk("R10 line low without power", int'(init_drive_low), 1);
    pwr_good = 1'b1;

    // Directed: full sequence with an external hold, then stray strobes
    do_config(4, 0, fin);
    clr_done = 1'b1;
    tick();
    clr_done = 1'b0;
    chk("R12 clr_done ignored clr_req", int'(clr_req), 0);
    chk("R12 clr_done ignored line", int'(init_drive_low), 0);
    load_done = 1'b1;
    tick();
    load_done = 1'b0;
    chk("R11 no gsr in live", int'(gsr), 0);
    chk("R11 done kept", int'(done), 1);
    prog_abort();

    // Directed: supply drop after completion
    do_config(0, 0, fin);
    pwr_good = 1'b0;
    tick();
    chk("R10 clr_req", int'(clr_req), 0);
    chk("R10 init_drive_low", int'(init_drive_low), 1);
    chk("R10 done", int'(done), 0);
    chk("R10 gts_hold", int'(gts_hold), 1);
    chk("R10 gwe_hold", int'(gwe_hold), 1);
    pwr_good = 1'b1;

    // Directed: clr_done while prog_n held Low is ignored
    prog_n   = 1'b0;
    clr_done = 1'b1;
    tick();
    tick();
    clr_done = 1'b0;
    prog_n   = 1'b1;
    chk("R12 clear held by prog", int'(clr_req), 1);

    // Random mix of holds, aborts and post-completion events
    for (int it = 0; it < 40; it++) begin
      hold = $urandom_range(0, 6);
      ab   = $urandom_range(0, 6);
      if (ab > 3) ab = 0;
      do_config(hold, ab, fin);
      if (fin) begin
        act = $urandom_range(0, 2);
        if (act == 0) begin
          prog_abort();
        end else if (act == 1) begin
          pwr_good = 1'b0;
          tick();
          chk("R10 done dropped", int'(done), 0);
          chk("R10 gwe_hold", int'(gwe_hold), 1);
          pwr_good = 1'b1;
        end else begin
          load_done = 1'b1;
          clr_done  = 1'b1;
          tick();
          load_done = 1'b0;
          clr_done  = 1'b0;
          chk("R11 gsr idle", int'(gsr), 0);
          chk("R12 no clear", int'(clr_req), 0);
          prog_abort();
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule